// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits on a host's I/O port bus and turns accesses at two small port windows into PCI configuration-space transactions. A 32-bit address register holds the target of the next configuration access: an enable flag, a bus number, a device/function number and a dword register offset. A 4-byte data window next to it carries the data. A byte, word or dword access to the data window becomes one configuration read or write request. The request carries the bus, the device/function, the dword-aligned register offset and a byte-enable mask taken from the position of the access inside the window.

Requests go to downstream configuration space over a request/acknowledge handshake. If no acknowledge comes within a fixed number of cycles, the device is taken to be absent. The host bridge answers for itself at bus 0, device/function 0. For those reads it returns a fixed identity header without raising a downstream request, and it drops all writes to it. Each I/O access the block claims ends with a one-cycle `ioReady` pulse.

Top module: `cfg_port_decoder`

## Requirements
- R1: A dword (`ioLen`=2) write at I/O address 0x0CF8 loads the 32-bit address register. A dword read at 0x0CF8 returns exactly the last value written, all 32 bits included.
- R2: An access in 0x0CF8..0x0CFB that is not a dword at 0x0CF8 is still claimed. A write of this kind leaves the address register unchanged, and a read of this kind returns 0xFFFFFFFF.
- R3: While bit 31 of the address register is 0, a data-window access (0x0CFC..0x0CFF) raises no request and has no effect, and a read returns 0xFFFFFFFF.
- R4: A request puts bits 23:16 of the address register on `cfgBus` and bits 15:8 on `cfgDevFn`, where device/function bits 7:3 are the device number and bits 2:0 are the function. `cfgReg` is {bits 7:2, 2'b00}.
- R5: `ioLen` 0, 1 and 2 mean 1, 2 and 4 bytes. `cfgBe` is the size mask shifted left by `ioAddr[1:0]`, and `cfgWdata` is `ioWdata` shifted left by 8 × `ioAddr[1:0]`.
- R6: Read data is the acknowledged dword shifted right by 8 × `ioAddr[1:0]`, with the bytes above the access size returned as zero.
- R7: A data-window access whose offset plus size exceeds 4 bytes, or that has `ioLen`=3, is rejected. It raises no request, and a read returns 0xFFFFFFFF.
- R8: If `cfgAck` does not arrive, `cfgReq` stays high for exactly TIMEOUT cycles and then drops. The access completes, and a read returns 0xFFFFFFFF.
- R9: With bus 0 and device/function 0, reads are served locally with no request. Dword 0x00 reads 0x12378086 (device 0x1237, vendor 0x8086). Dword 0x08 reads 0x06000002 (base class 0x06, subclass 0x00, revision 0x02). Dword 0x0C reads header type 0x00, and all other dwords read 0.
- R10: Writes addressed to the host bridge header are dropped: they raise no request and leave every value unchanged.
- R11: `cfgReq` and all request fields hold steady from the start of a request until the cycle after `cfgAck` or the timeout. `ioReady` is a single-cycle pulse per claimed access.
- R12: An I/O access outside 0x0CF8..0x0CFF is not claimed. It gets no `ioReady` and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioValid | input | 1 | I/O access present, held until ioReady |
| ioWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| ioAddr | input | 16 | I/O port address |
| ioLen | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| ioWdata | input | 32 | Write data, right-aligned |
| ioReady | output | 1 | One-cycle completion pulse |
| ioRdata | output | 32 | Read data, right-aligned, valid with ioReady |
| cfgReq | output | 1 | Configuration request outstanding |
| cfgWrite | output | 1 | Request is a write |
| cfgBus | output | 8 | Target bus number |
| cfgDevFn | output | 8 | Target device (7:3) and function (2:0) |
| cfgReg | output | 8 | Dword-aligned register offset |
| cfgBe | output | 4 | Byte enables for the dword |
| cfgWdata | output | 32 | Lane-positioned write data |
| cfgAck | input | 1 | Downstream completion, only while cfgReq |
| cfgRdata | input | 32 | Downstream read dword, valid with cfgAck |

## Verification
The assertions take it for granted that the I/O master holds `ioValid` and its address, size and data steady until it sees `ioReady`, and drops `ioValid` in the cycle that follows. They also assume that downstream raises `cfgAck` only while `cfgReq` is high, for a single cycle per request. The bench keeps within these terms. Its transaction task drives all fields at once and releases them at the edge where the pulse is observed. Its downstream responder acknowledges after a programmable delay, clears the acknowledge on the next cycle and never answers device 31, so the timeout path can be reached.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;

  typedef enum logic [1:0] {
    SRC_ADDR,
    SRC_ONES,
    SRC_IDENT,
    SRC_DOWN
  } rdSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   addrWr;   // load address register from ioWdata
    logic   capture;  // latch offset, size and write data of a data access
    logic   rdLoad;   // load read result
    rdSrc_e rdSrc;    // which source feeds the read result
  } ctlStrobes_t;

  function automatic logic [2:0] lenBytes(input logic [1:0] len);
    case (len)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [3:0] laneBe(input logic [1:0] off, input logic [1:0] len);
    logic [3:0] m;
    case (len)
      2'd0:    m = 4'b0001;
      2'd1:    m = 4'b0011;
      2'd2:    m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m << off;
  endfunction

  function automatic logic crossesWindow(input logic [1:0] off, input logic [1:0] len);
    logic [3:0] endPos;
    endPos = {2'b00, off} + {1'b0, lenBytes(len)};
    return (len == 2'd3) || (endPos > 4'd4);
  endfunction

  function automatic logic [31:0] laneFmt(input logic [31:0] w, input logic [1:0] off,
                                          input logic [1:0] len);
    logic [31:0] s;
    s = w >> {off, 3'b000};
    case (len)
      2'd0:    return {24'h0, s[7:0]};
      2'd1:    return {16'h0, s[15:0]};
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/cfg_dec_ctrl.sv
module cfg_dec_ctrl
  import cfg_dec_pkg::*;
#(
  parameter int          IO_AW     = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int          TIMEOUT   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioValid,
  input  logic             ioWrite,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [1:0]       ioLen,
  input  logic             cfgEnable,
  input  logic             hostHit,
  input  logic             cfgAck,
  output ctlStrobes_t      strb,
  output logic             ioReady,
  output logic             cfgReq,
  output logic             cfgWrite
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
  localparam logic [IO_AW-1:0] ADDR_BASE = IO_AW'(ADDR_PORT);
  localparam logic [IO_AW-1:0] DATA_BASE = IO_AW'(DATA_PORT);

  ctlState_e state, nextState;
  logic [CW-1:0] waitCnt;
  logic cntClr, cntInc;
  logic wrQ;

  logic inAddrWin, inDataWin, addrOk, rejectAcc;

  assign inAddrWin = (ioAddr[IO_AW-1:2] == ADDR_BASE[IO_AW-1:2]);
  assign inDataWin = (ioAddr[IO_AW-1:2] == DATA_BASE[IO_AW-1:2]);
  assign addrOk    = (ioAddr[1:0] == 2'b00) && (ioLen == 2'd2);
  assign rejectAcc = !cfgEnable || crossesWindow(ioAddr[1:0], ioLen);

  always_comb begin
    nextState = state;
    strb      = '0;
    cntClr    = 1'b0;
    cntInc    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ioValid && inAddrWin) begin
          nextState = ST_DONE;
          if (addrOk) begin
            strb.addrWr = ioWrite;
            strb.rdLoad = !ioWrite;
            strb.rdSrc  = SRC_ADDR;
          end else begin
            strb.rdLoad = !ioWrite;
            strb.rdSrc  = SRC_ONES;
          end
        end else if (ioValid && inDataWin) begin
          strb.capture = 1'b1;
          if (rejectAcc) begin
            nextState   = ST_DONE;
            strb.rdLoad = !ioWrite;
            strb.rdSrc  = SRC_ONES;
          end else if (hostHit) begin
            nextState   = ST_DONE;
            strb.rdLoad = !ioWrite;
            strb.rdSrc  = SRC_IDENT;
          end else begin
            nextState = ST_WAIT;
            cntClr    = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (cfgAck) begin
          nextState   = ST_DONE;
          strb.rdLoad = !wrQ;
          strb.rdSrc  = SRC_DOWN;
        end else if (waitCnt == CNT_LAST) begin
          nextState   = ST_DONE;
          strb.rdLoad = !wrQ;
          strb.rdSrc  = SRC_ONES;
        end else begin
          cntInc = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      wrQ     <= 1'b0;
    end else begin
      state <= nextState;
      if (cntClr)      waitCnt <= '0;
      else if (cntInc) waitCnt <= waitCnt + 1'b1;
      if (strb.capture) wrQ <= ioWrite;
    end
  end

  assign ioReady  = (state == ST_DONE);
  assign cfgReq   = (state == ST_WAIT);
  assign cfgWrite = wrQ;

endmodule

// File: rtl/cfg_dec_datapath.sv
module cfg_dec_datapath
  import cfg_dec_pkg::*;
#(
  parameter logic [7:0]  HOST_BUS    = 8'h00,
  parameter logic [7:0]  HOST_DEVFN  = 8'h00,
  parameter logic [15:0] VENDOR_ID   = 16'h8086,
  parameter logic [15:0] DEVICE_ID   = 16'h1237,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [23:0] CLASS_CODE  = 24'h060000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic [1:0]  ioOff,
  input  logic [1:0]  ioLen,
  input  logic [31:0] ioWdata,
  input  logic [31:0] cfgRdata,
  output logic        cfgEnable,
  output logic        hostHit,
  output logic [31:0] ioRdata,
  output logic [7:0]  cfgBus,
  output logic [7:0]  cfgDevFn,
  output logic [7:0]  cfgReg,
  output logic [3:0]  cfgBe,
  output logic [31:0] cfgWdata
);

  localparam logic [31:0] ALL_ONES = '1;

  logic [31:0] addrReg;
  logic [1:0]  offQ, lenQ;
  logic [31:0] wdataQ;
  logic [31:0] identWord;

  // fixed header of the host bridge, indexed by dword
  always_comb begin
    case (addrReg[7:2])
      6'd0:    identWord = {DEVICE_ID, VENDOR_ID};
      6'd2:    identWord = {CLASS_CODE, REVISION};
      6'd3:    identWord = {8'h00, HEADER_TYPE, 16'h0000};
      default: identWord = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      offQ    <= '0;
      lenQ    <= '0;
      wdataQ  <= '0;
      ioRdata <= '0;
    end else begin
      if (strb.addrWr) addrReg <= ioWdata;
      if (strb.capture) begin
        offQ   <= ioOff;
        lenQ   <= ioLen;
        wdataQ <= ioWdata;
      end
      if (strb.rdLoad) begin
        case (strb.rdSrc)
          SRC_ADDR:  ioRdata <= addrReg;
          SRC_ONES:  ioRdata <= ALL_ONES;
          SRC_IDENT: ioRdata <= laneFmt(identWord, ioOff, ioLen);
          SRC_DOWN:  ioRdata <= laneFmt(cfgRdata, offQ, lenQ);
          default:   ioRdata <= ALL_ONES;
        endcase
      end
    end
  end

  assign cfgEnable = addrReg[31];
  assign cfgBus    = addrReg[23:16];
  assign cfgDevFn  = addrReg[15:8];
  assign cfgReg    = {addrReg[7:2], 2'b00};
  assign hostHit   = (addrReg[23:16] == HOST_BUS) && (addrReg[15:8] == HOST_DEVFN);
  assign cfgBe     = laneBe(offQ, lenQ);
  assign cfgWdata  = wdataQ << {offQ, 3'b000};

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_dec_pkg::*;
#(
  parameter int          IO_AW      = 16,
  parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          TIMEOUT    = 16,
  parameter logic [7:0]  HOST_BUS   = 8'h00,
  parameter logic [7:0]  HOST_DEVFN = 8'h00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioValid,
  input  logic             ioWrite,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic [1:0]       ioLen,
  input  logic [31:0]      ioWdata,
  output logic             ioReady,
  output logic [31:0]      ioRdata,
  output logic             cfgReq,
  output logic             cfgWrite,
  output logic [7:0]       cfgBus,
  output logic [7:0]       cfgDevFn,
  output logic [7:0]       cfgReg,
  output logic [3:0]       cfgBe,
  output logic [31:0]      cfgWdata,
  input  logic             cfgAck,
  input  logic [31:0]      cfgRdata
);

  ctlStrobes_t strb;
  logic cfgEnable, hostHit;

  cfg_dec_ctrl #(
    .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .TIMEOUT(TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioLen(ioLen), .cfgEnable(cfgEnable), .hostHit(hostHit), .cfgAck(cfgAck),
    .strb(strb), .ioReady(ioReady), .cfgReq(cfgReq), .cfgWrite(cfgWrite)
  );

  cfg_dec_datapath #(
    .HOST_BUS(HOST_BUS), .HOST_DEVFN(HOST_DEVFN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioOff(ioAddr[1:0]), .ioLen(ioLen),
    .ioWdata(ioWdata), .cfgRdata(cfgRdata), .cfgEnable(cfgEnable), .hostHit(hostHit),
    .ioRdata(ioRdata), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn), .cfgReg(cfgReg),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata)
  );

endmodule

// File: rtl/cfg_dec_checker.sv
module cfg_dec_checker #(
  parameter int          IO_AW      = 16,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          TIMEOUT    = 16,
  parameter logic [7:0]  HOST_BUS   = 8'h00,
  parameter logic [7:0]  HOST_DEVFN = 8'h00
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioValid,
  input logic [IO_AW-1:0] ioAddr,
  input logic             ioReady,
  input logic             cfgReq,
  input logic             cfgWrite,
  input logic [7:0]       cfgBus,
  input logic [7:0]       cfgDevFn,
  input logic [7:0]       cfgReg,
  input logic [3:0]       cfgBe,
  input logic [31:0]      cfgWdata,
  input logic             cfgAck
);

  localparam logic [IO_AW-1:0] DATA_BASE = IO_AW'(DATA_PORT);
  localparam int CW = $clog2(TIMEOUT + 2);

  logic [CW-1:0] reqRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       reqRun <= '0;
    else if (cfgReq) reqRun <= reqRun + 1'b1;
    else             reqRun <= '0;
  end

  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (reqRun < CW'(TIMEOUT))); // R8

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && $past(cfgReq)) |-> $stable({cfgWrite, cfgBus, cfgDevFn, cfgReg, cfgBe, cfgWdata})); // R11

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ioReady |=> !ioReady); // R11

  AST_ACK_IN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> cfgReq); // R11

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (cfgBe inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                              4'b0011, 4'b0110, 4'b1100, 4'b1111})); // R5

  AST_REQ_FROM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgReq) |-> ($past(ioValid) && ($past(ioAddr[IO_AW-1:2]) == DATA_BASE[IO_AW-1:2]))); // R12

  AST_HOST_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> !((cfgBus == HOST_BUS) && (cfgDevFn == HOST_DEVFN))); // R9

endmodule

bind cfg_port_decoder cfg_dec_checker #(
  .IO_AW(IO_AW), .DATA_PORT(DATA_PORT), .TIMEOUT(TIMEOUT),
  .HOST_BUS(HOST_BUS), .HOST_DEVFN(HOST_DEVFN)
) u_chk (
  .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioAddr(ioAddr), .ioReady(ioReady),
  .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn),
  .cfgReg(cfgReg), .cfgBe(cfgBe), .cfgWdata(cfgWdata), .cfgAck(cfgAck)
);

// File: tb/cfg_port_decoder_bench.sv
`timescale 1ns/1ps
module cfg_port_decoder_bench;

  localparam int TIMEOUT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioValid = 1'b0, ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0] ioLen = '0;
  logic [31:0] ioWdata = '0;
  logic ioReady;
  logic [31:0] ioRdata;
  logic cfgReq, cfgWrite;
  logic [7:0] cfgBus, cfgDevFn, cfgReg;
  logic [3:0] cfgBe;
  logic [31:0] cfgWdata;
  logic cfgAck = 1'b0;
  logic [31:0] cfgRdata = '0;

  always #4 clk = ~clk;

  cfg_port_decoder #(.TIMEOUT(TIMEOUT)) u_cfg_port_decoder (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioLen(ioLen), .ioWdata(ioWdata), .ioReady(ioReady), .ioRdata(ioRdata),
    .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDevFn(cfgDevFn),
    .cfgReg(cfgReg), .cfgBe(cfgBe), .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // downstream model: one shared register file, device 31 absent
  logic [31:0] mem [0:63];
  int ackDelay = 0;
  int reqCycles = 0;
  bit reqSeen = 0;
  logic lastWrite;
  logic [7:0] lastBus, lastDevFn, lastReg;
  logic [3:0] lastBe;
  logic [31:0] lastWdata;
  bit prevReady = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!rstN) cfgAck = 1'b0;
    else if (cfgAck) cfgAck = 1'b0;
    else if (cfgReq) begin
      reqCycles++;
      reqSeen = 1;
      if (reqCycles == 1) begin
        lastWrite = cfgWrite; lastBus = cfgBus; lastDevFn = cfgDevFn;
        lastReg = cfgReg; lastBe = cfgBe; lastWdata = cfgWdata;
      end
      if (cfgDevFn[7:3] != 5'd31 && reqCycles > ackDelay) begin
        cfgAck = 1'b1;
        cfgRdata = mem[cfgReg[7:2]];
        if (cfgWrite)
          for (int b = 0; b < 4; b++)
            if (cfgBe[b]) mem[cfgReg[7:2]][8*b +: 8] = cfgWdata[8*b +: 8];
      end
    end
  end

  // per-cycle compare of the completion pulse shape
  always @(negedge clk) begin
    if (rstN) begin
      if (ioReady && prevReady) begin
        miscompares++;
        $display("FAIL R11 ioReady high two cycles: actual 1 expected 0");
      end
      prevReady = ioReady;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ioAcc(input logic wr, input logic [15:0] a, input logic [1:0] len,
                       input logic [31:0] wd, input int maxWait,
                       output logic [31:0] rd, output logic seen);
    reqSeen = 0;
    reqCycles = 0;
    seen = 0;
    rd = 'x;
    @(negedge clk);
    ioValid = 1'b1; ioWrite = wr; ioAddr = a; ioLen = len; ioWdata = wd;
    for (int i = 0; i < maxWait; i++) begin
      @(negedge clk);
      if (ioReady) begin
        seen = 1;
        rd = ioRdata;
        break;
      end
    end
    ioValid = 1'b0;
  endtask

  logic [31:0] rd;
  logic seen;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset ioReady", {31'h0, ioReady}, 32'h0);
    chk("R11 reset cfgReq", {31'h0, cfgReq}, 32'h0);

    // R1 address register readback, enable clear
    ioAcc(1, 16'h0CF8, 2, 32'h7F5AC3F1, 50, rd, seen);
    chk("R1 write claimed", {31'h0, seen}, 32'h1);
    ioAcc(0, 16'h0CF8, 2, 0, 50, rd, seen);
    chk("R1 readback", rd, 32'h7F5AC3F1);

    // R2 non-dword address port access
    ioAcc(1, 16'h0CF8, 1, 32'h0000FFFF, 50, rd, seen);
    ioAcc(0, 16'h0CF8, 2, 0, 50, rd, seen);
    chk("R2 word write ignored", rd, 32'h7F5AC3F1);
    ioAcc(0, 16'h0CFA, 0, 0, 50, rd, seen);
    chk("R2 byte read ones", rd, 32'hFFFFFFFF);

    // R3 enable clear
    ioAcc(1, 16'h0CFC, 2, 32'h11223344, 50, rd, seen);
    chk("R3 write no request", {31'h0, reqSeen}, 32'h0);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R3 read ones", rd, 32'hFFFFFFFF);
    chk("R3 read no request", {31'h0, reqSeen}, 32'h0);

    // R4 request fields: bus 5, dev 5 fn 3, reg 0x47 -> 0x44
    ackDelay = 0;
    ioAcc(1, 16'h0CF8, 2, 32'h80052B47, 50, rd, seen);
    ioAcc(1, 16'h0CFC, 2, 32'hDEADBEEF, 50, rd, seen);
    chk("R4 bus", {24'h0, lastBus}, 32'h05);
    chk("R4 devfn", {24'h0, lastDevFn}, 32'h2B);
    chk("R4 device number", {27'h0, lastDevFn[7:3]}, 32'h5);
    chk("R4 reg", {24'h0, lastReg}, 32'h44);
    chk("R4 write flag", {31'h0, lastWrite}, 32'h1);
    chk("R5 dword be", {28'h0, lastBe}, 32'hF);
    chk("R5 dword wdata", lastWdata, 32'hDEADBEEF);

    // R5 byte lane write
    ioAcc(1, 16'h0CFE, 0, 32'h000000A5, 50, rd, seen);
    chk("R5 byte be", {28'h0, lastBe}, 32'h4);
    chk("R5 byte wdata", lastWdata, 32'h00A50000);

    // R6 reads
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R6 dword read", rd, 32'hDEA5BEEF);
    ioAcc(0, 16'h0CFE, 1, 0, 50, rd, seen);
    chk("R6 word read", rd, 32'h0000DEA5);
    chk("R5 word be", {28'h0, lastBe}, 32'hC);
    ioAcc(0, 16'h0CFD, 0, 0, 50, rd, seen);
    chk("R6 byte read", rd, 32'h000000BE);
    chk("R5 byte read be", {28'h0, lastBe}, 32'h2);

    // R7 window crossing
    ioAcc(0, 16'h0CFF, 1, 0, 50, rd, seen);
    chk("R7 word cross ones", rd, 32'hFFFFFFFF);
    chk("R7 word cross no request", {31'h0, reqSeen}, 32'h0);
    ioAcc(1, 16'h0CFD, 2, 32'h01020304, 50, rd, seen);
    chk("R7 dword cross no request", {31'h0, reqSeen}, 32'h0);
    ioAcc(0, 16'h0CFC, 3, 0, 50, rd, seen);
    chk("R7 bad size ones", rd, 32'hFFFFFFFF);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R7 memory untouched", rd, 32'hDEA5BEEF);

    // R8 absent device
    ioAcc(1, 16'h0CF8, 2, 32'h8002F800, 50, rd, seen);
    ioAcc(0, 16'h0CFC, 2, 0, 60, rd, seen);
    chk("R8 timeout read ones", rd, 32'hFFFFFFFF);
    chk("R8 request length", reqCycles, TIMEOUT);
    ioAcc(1, 16'h0CFC, 2, 32'h55, 60, rd, seen);
    chk("R8 timeout write completes", {31'h0, seen}, 32'h1);
    chk("R8 write request length", reqCycles, TIMEOUT);

    // R11 delayed acknowledge
    ackDelay = 5;
    ioAcc(1, 16'h0CF8, 2, 32'h80052B44, 50, rd, seen);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R11 delayed read data", rd, 32'hDEA5BEEF);
    chk("R11 request held", reqCycles, 6);
    ackDelay = 0;

    // R9 host bridge identity
    ioAcc(1, 16'h0CF8, 2, 32'h80000000, 50, rd, seen);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R9 id dword", rd, 32'h12378086);
    chk("R9 no request", {31'h0, reqSeen}, 32'h0);
    ioAcc(0, 16'h0CFE, 1, 0, 50, rd, seen);
    chk("R9 device id", rd, 32'h00001237);
    ioAcc(1, 16'h0CF8, 2, 32'h80000008, 50, rd, seen);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R9 class/revision", rd, 32'h06000002);
    ioAcc(0, 16'h0CFF, 0, 0, 50, rd, seen);
    chk("R9 base class", rd, 32'h00000006);
    ioAcc(1, 16'h0CF8, 2, 32'h8000000C, 50, rd, seen);
    ioAcc(0, 16'h0CFE, 0, 0, 50, rd, seen);
    chk("R9 header type", rd, 32'h00000000);

    // R10 host bridge writes dropped
    ioAcc(1, 16'h0CF8, 2, 32'h80000000, 50, rd, seen);
    ioAcc(1, 16'h0CFC, 2, 32'hFFFFFFFF, 50, rd, seen);
    chk("R10 write no request", {31'h0, reqSeen}, 32'h0);
    ioAcc(0, 16'h0CFC, 2, 0, 50, rd, seen);
    chk("R10 id unchanged", rd, 32'h12378086);

    // R12 unclaimed addresses
    ioAcc(0, 16'h0CF4, 2, 0, 6, rd, seen);
    chk("R12 below window unclaimed", {31'h0, seen}, 32'h0);
    ioAcc(1, 16'h0D00, 2, 32'h1, 6, rd, seen);
    chk("R12 above window unclaimed", {31'h0, seen}, 32'h0);
    chk("R12 no request", {31'h0, reqSeen}, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule